// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and three memories. The memories are a 512KB SRAM, a Flash device and a 1KB on-chip boot ROM. Each CPU address is sorted by its 16KB region, `cpu_addr[15:14]`. Three I/O registers decide the route: one paging control byte and two window registers. The block turns the address into a 19-bit physical byte address and one memory select. It also returns the selected memory's read data to the CPU.

In the physical SRAM, pages 0x00..0x03 hold the four base RAM pages. Pages 0x04..0x07 hold eight 8KB ROM images, two per page. Page 0x08 holds the 8KB OS image in its lower half. Pages 0x09..0x0B are scratch space. Pages 0x0C..0x1F are twenty extended RAM pages. The mapper has two maps: a ROM-plus-RAM map and an all-RAM map. In page numbers 14 and 15, windows open onto any 16KB SRAM or Flash page. After reset, the boot ROM is mirrored across the lowest region, so the CPU starts executing there.

A "slot" numbers the RAM pages in one list. Slots 0..3 are SRAM pages 0x00..0x03. Slot s from 4 to 23 is SRAM page s+8. A slot above 23 does not exist.

Top module: `mem_page_mapper`

## Requirements
- R1: A synchronous active-high reset sets the control byte to 0x8F and both window registers to 0x00. The flash flag is then high, and address 0x0000 selects the on-chip ROM.
- R2: When `io_wr` is high at a clock edge and `io_addr` is 0x00, the control byte takes `io_wdata`. Its bit 7 selects the all-RAM map, bits 6..4 select the ROM image, and bits 3..0 select the page number. Reading port 0x00 returns the byte as written.
- R3: Writes to port 0xD0 load window 1 and writes to port 0xD1 load window 2. Each keeps only `io_wdata[4:0]`. Reading either port returns the value with bits 7..5 at zero. Reading any other port returns 0xFF.
- R4: Addresses 0xC000..0xFFFF always select SRAM page 0x00, with `phys_addr` = {5'h00, cpu_addr[13:0]}, in either map.
- R5: In the ROM map, 0x0000..0x1FFF selects SRAM at 0x20000 + cpu_addr[12:0]. In the same map, 0x2000..0x3FFF selects SRAM at 0x10000 + n*0x2000 + cpu_addr[12:0], where n is the ROM-select field.
- R6: In the ROM map, with page number p from 0 to 11, 0x4000..0x7FFF shows slot 2p+2 and 0x8000..0xBFFF shows slot 2p+1.
- R7: In the all-RAM map, page 0 shows slots 3, 2 and 1 at 0x0000, 0x4000 and 0x8000. Pages 1..7 show slots 3p+1, 3p+2 and 3p+3 at those addresses.
- R8: In pages 14 and 15 of either map, 0x4000..0x7FFF selects SRAM page window 1. In page 14, 0x8000..0xBFFF selects SRAM page window 2. In page 15, that range selects Flash page window 2. In every case `phys_addr` = {window, cpu_addr[13:0]}.
- R9: In the all-RAM map with page 15, 0x0000..0x3FFF selects the on-chip ROM, with `phys_addr` = {9'b0, cpu_addr[9:0]}. The 1KB image therefore repeats 16 times.
- R10: A region that the map leaves empty raises no select. This covers a missing slot, pages 12..13 in the ROM map, pages 8..14 at 0x0000 in the all-RAM map, and pages 8..13 elsewhere. `cpu_rdata` then reads 0xFF.
- R11: `cpu_rdata` equals `sram_rdata`, `flash_rdata` or `rom_rdata`, following whichever select is high.
- R12: `flash_visible` is high exactly when the page field is 15. At most one select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read-back data |
| cpu_addr | input | 16 | CPU memory address |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| sram_rdata | input | 8 | Data from the SRAM |
| flash_rdata | input | 8 | Data from the Flash |
| rom_rdata | input | 8 | Data from the on-chip ROM |
| phys_addr | output | 19 | Physical byte address |
| sram_cs | output | 1 | SRAM select |
| flash_cs | output | 1 | Flash select |
| rom_cs | output | 1 | On-chip ROM select |
| flash_visible | output | 1 | Flash is mapped in the current page |

## Verification
The mapping logic is combinational, so a wrong page decode shows at the ports in the same cycle the address is driven. It appears as a wrong select, a wrong upper `phys_addr` field, or a stray 0xFF on `cpu_rdata`. A corrupted register is different: it shows only when an address in the affected region is presented. For that reason the bench walks each region under many control bytes. It also reads every register back through its port one cycle after it is written.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    localparam int PAGE_W     = 5;                 // 16KB page number width
    localparam int OFS_W      = 14;                // offset within a 16KB page
    localparam int PHYS_W     = PAGE_W + OFS_W;    // physical byte address width
    localparam int UNIT_W     = PHYS_W - 13;       // 8KB image index width
    localparam int ROM_AW     = 10;                // on-chip ROM address width
    localparam int BASE_SLOTS = 4;                 // base RAM pages
    localparam int NUM_SLOTS  = 24;                // base + extended RAM pages
    localparam int EXT_SHIFT  = 8;                 // extended slot s lives at page s+8
    localparam int OS_UNIT    = 16;                // 8KB unit holding the OS image
    localparam int ROM_UNIT0  = 8;                 // 8KB unit of ROM image 0
    localparam logic [3:0] WIN_SRAM_PG  = 4'd14;
    localparam logic [3:0] WIN_FLASH_PG = 4'd15;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_SRAM,
        TGT_FLASH,
        TGT_ROM
    } tgt_e;

    typedef struct packed {
        logic       all_ram;
        logic [2:0] rom_sel;
        logic [3:0] page;
    } ctrl_t;

    typedef struct packed {
        tgt_e              tgt;
        logic [PHYS_W-1:0] addr;
    } route_t;

    function automatic route_t no_route();
        route_t r;
        r.tgt  = TGT_NONE;
        r.addr = '0;
        return r;
    endfunction

    function automatic route_t page_route(tgt_e t, logic [PAGE_W-1:0] pg,
                                          logic [OFS_W-1:0] ofs);
        route_t r;
        r.tgt  = t;
        r.addr = {pg, ofs};
        return r;
    endfunction

    // Slot list: base pages first, then the extended pages above the ROM area.
    function automatic route_t slot_route(int unsigned slot, logic [OFS_W-1:0] ofs);
        if (slot < BASE_SLOTS)
            return page_route(TGT_SRAM, PAGE_W'(slot), ofs);
        else if (slot < NUM_SLOTS)
            return page_route(TGT_SRAM, PAGE_W'(slot + EXT_SHIFT), ofs);
        else
            return no_route();
    endfunction

    function automatic route_t unit_route(int unsigned unit, logic [12:0] ofs);
        route_t r;
        r.tgt  = TGT_SRAM;
        r.addr = {UNIT_W'(unit), ofs};
        return r;
    endfunction

endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
#(
    parameter logic [7:0] CTRL_PORT  = 8'h00,
    parameter logic [7:0] WIN1_PORT  = 8'hD0,
    parameter logic [7:0] WIN2_PORT  = 8'hD1,
    parameter logic [7:0] CTRL_RESET = 8'h8F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    output ctrl_t             ctrl,
    output logic [PAGE_W-1:0] win1,
    output logic [PAGE_W-1:0] win2,
    output logic [7:0]        io_rdata
);

    localparam int NUM_WIN = 2;
    localparam logic [7:0] WIN_PORTS [NUM_WIN] = '{WIN1_PORT, WIN2_PORT};

    ctrl_t             ctrl_q;
    logic [PAGE_W-1:0] win_q [NUM_WIN];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= ctrl_t'(CTRL_RESET);
        else if (io_wr && io_addr == CTRL_PORT)
            ctrl_q <= ctrl_t'(io_wdata);
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst)
                win_q[w] <= '0;
            else if (io_wr && io_addr == WIN_PORTS[w])
                win_q[w] <= io_wdata[PAGE_W-1:0];
        end

        p_win_load_r3: assert property (@(posedge clk) disable iff (rst)
            (io_wr && io_addr == WIN_PORTS[w]) |=> (win_q[w] == $past(io_wdata[PAGE_W-1:0])));
        p_win_hold_r3: assert property (@(posedge clk) disable iff (rst)
            !(io_wr && io_addr == WIN_PORTS[w]) |=> $stable(win_q[w]));
    end

    assign ctrl = ctrl_q;
    assign win1 = win_q[0];
    assign win2 = win_q[1];

    always_comb begin
        if (io_addr == CTRL_PORT)
            io_rdata = ctrl_q;
        else if (io_addr == WIN1_PORT)
            io_rdata = {{(8-PAGE_W){1'b0}}, win_q[0]};
        else if (io_addr == WIN2_PORT)
            io_rdata = {{(8-PAGE_W){1'b0}}, win_q[1]};
        else
            io_rdata = 8'hFF;
    end

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == CTRL_PORT) |=> $stable(ctrl_q));

endmodule

// File: rtl/mapper_decode.sv
module mapper_decode
    import mapper_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [PAGE_W-1:0] win1,
    input  logic [PAGE_W-1:0] win2,
    input  logic [1:0]        region,
    input  logic [OFS_W-1:0]  ofs,
    output route_t            route
);

    int unsigned pn;
    logic        windowed;

    always_comb begin
        pn       = 32'(ctrl.page);
        windowed = (ctrl.page == WIN_SRAM_PG) || (ctrl.page == WIN_FLASH_PG);
        route    = no_route();
        case (region)
            2'd0: begin
                if (!ctrl.all_ram) begin
                    if (!ofs[13])
                        route = unit_route(OS_UNIT, ofs[12:0]);
                    else
                        route = unit_route(ROM_UNIT0 + 32'(ctrl.rom_sel), ofs[12:0]);
                end else if (ctrl.page == WIN_FLASH_PG) begin
                    route.tgt  = TGT_ROM;
                    route.addr = {{(PHYS_W-ROM_AW){1'b0}}, ofs[ROM_AW-1:0]};
                end else if (pn == 0) begin
                    route = slot_route(3, ofs);
                end else if (pn <= 7) begin
                    route = slot_route(3 * pn + 1, ofs);
                end
            end
            2'd1: begin
                if (windowed)
                    route = page_route(TGT_SRAM, win1, ofs);
                else if (!ctrl.all_ram && pn <= 11)
                    route = slot_route(2 * pn + 2, ofs);
                else if (ctrl.all_ram && pn == 0)
                    route = slot_route(2, ofs);
                else if (ctrl.all_ram && pn <= 7)
                    route = slot_route(3 * pn + 2, ofs);
            end
            2'd2: begin
                if (ctrl.page == WIN_FLASH_PG)
                    route = page_route(TGT_FLASH, win2, ofs);
                else if (ctrl.page == WIN_SRAM_PG)
                    route = page_route(TGT_SRAM, win2, ofs);
                else if (!ctrl.all_ram && pn <= 11)
                    route = slot_route(2 * pn + 1, ofs);
                else if (ctrl.all_ram && pn == 0)
                    route = slot_route(1, ofs);
                else if (ctrl.all_ram && pn <= 7)
                    route = slot_route(3 * pn + 3, ofs);
            end
            default: route = slot_route(0, ofs);
        endcase
    end

endmodule

// File: rtl/mapper_select.sv
module mapper_select
    import mapper_pkg::*;
(
    input  tgt_e       tgt,
    input  logic [7:0] sram_rdata,
    input  logic [7:0] flash_rdata,
    input  logic [7:0] rom_rdata,
    output logic       sram_cs,
    output logic       flash_cs,
    output logic       rom_cs,
    output logic [7:0] cpu_rdata
);

    always_comb begin
        sram_cs   = (tgt == TGT_SRAM);
        flash_cs  = (tgt == TGT_FLASH);
        rom_cs    = (tgt == TGT_ROM);
        unique case (tgt)
            TGT_SRAM:  cpu_rdata = sram_rdata;
            TGT_FLASH: cpu_rdata = flash_rdata;
            TGT_ROM:   cpu_rdata = rom_rdata;
            default:   cpu_rdata = 8'hFF;
        endcase
    end

endmodule

// File: rtl/mem_page_mapper.sv
module mem_page_mapper
    import mapper_pkg::*;
#(
    parameter logic [7:0] CTRL_PORT  = 8'h00,
    parameter logic [7:0] WIN1_PORT  = 8'hD0,
    parameter logic [7:0] WIN2_PORT  = 8'hD1,
    parameter logic [7:0] CTRL_RESET = 8'h8F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [15:0]       cpu_addr,
    output logic [7:0]        cpu_rdata,
    input  logic [7:0]        sram_rdata,
    input  logic [7:0]        flash_rdata,
    input  logic [7:0]        rom_rdata,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              sram_cs,
    output logic              flash_cs,
    output logic              rom_cs,
    output logic              flash_visible
);

    ctrl_t             ctrl;
    logic [PAGE_W-1:0] win1;
    logic [PAGE_W-1:0] win2;
    route_t            route;

    mapper_regs #(
        .CTRL_PORT (CTRL_PORT),
        .WIN1_PORT (WIN1_PORT),
        .WIN2_PORT (WIN2_PORT),
        .CTRL_RESET(CTRL_RESET)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .ctrl    (ctrl),
        .win1    (win1),
        .win2    (win2),
        .io_rdata(io_rdata)
    );

    mapper_decode u_decode (
        .ctrl  (ctrl),
        .win1  (win1),
        .win2  (win2),
        .region(cpu_addr[15:14]),
        .ofs   (cpu_addr[OFS_W-1:0]),
        .route (route)
    );

    mapper_select u_select (
        .tgt        (route.tgt),
        .sram_rdata (sram_rdata),
        .flash_rdata(flash_rdata),
        .rom_rdata  (rom_rdata),
        .sram_cs    (sram_cs),
        .flash_cs   (flash_cs),
        .rom_cs     (rom_cs),
        .cpu_rdata  (cpu_rdata)
    );

    assign phys_addr     = route.addr;
    assign flash_visible = (ctrl.page == WIN_FLASH_PG);

    p_one_select_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sram_cs, flash_cs, rom_cs}));
    p_flash_flag_r12: assert property (@(posedge clk) disable iff (rst)
        flash_cs |-> flash_visible);
    p_common_page_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b11) |-> (sram_cs && phys_addr[PHYS_W-1:OFS_W] == '0));
    p_rom_low_r9: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> (cpu_addr[15:14] == 2'b00 && flash_visible));
    p_empty_ff_r10: assert property (@(posedge clk) disable iff (rst)
        !(sram_cs || flash_cs || rom_cs) |-> (cpu_rdata == 8'hFF));

endmodule

// File: tb/mem_page_mapper_bench.sv
`timescale 1ns/1ps
module mem_page_mapper_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_rdata;
    logic [7:0]  sram_rdata  = 8'hA5;
    logic [7:0]  flash_rdata = 8'h5A;
    logic [7:0]  rom_rdata   = 8'h3C;
    logic [18:0] phys_addr;
    logic        sram_cs, flash_cs, rom_cs, flash_visible;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    mem_page_mapper u_mem_page_mapper (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
        .sram_rdata(sram_rdata), .flash_rdata(flash_rdata), .rom_rdata(rom_rdata),
        .phys_addr(phys_addr), .sram_cs(sram_cs), .flash_cs(flash_cs),
        .rom_cs(rom_cs), .flash_visible(flash_visible)
    );

    // {req, ctrl, win1, win2, cpu_addr, cs{rom,flash,sram}, phys}
    localparam int NV = 29;
    localparam logic [65:0] VEC [NV] = '{
        {4'd5,  8'h00, 8'h00, 8'h00, 16'h0123, 3'b001, 19'h20123}, // R5 OS image
        {4'd5,  8'h50, 8'h00, 8'h00, 16'h2345, 3'b001, 19'h1A345}, // R5 ROM 5
        {4'd6,  8'h00, 8'h00, 8'h00, 16'h4010, 3'b001, 19'h08010}, // R6 page 0
        {4'd6,  8'h00, 8'h00, 8'h00, 16'h8001, 3'b001, 19'h04001}, // R6
        {4'd6,  8'h01, 8'h00, 8'h00, 16'h8002, 3'b001, 19'h0C002}, // R6 slot 3
        {4'd6,  8'h01, 8'h00, 8'h00, 16'h4003, 3'b001, 19'h30003}, // R6 slot 4
        {4'd6,  8'h03, 8'h00, 8'h00, 16'h4007, 3'b001, 19'h40007}, // R6
        {4'd6,  8'h03, 8'h00, 8'h00, 16'h8008, 3'b001, 19'h3C008}, // R6
        {4'd6,  8'h0B, 8'h00, 8'h00, 16'h8004, 3'b001, 19'h7C004}, // R6 last slot
        {4'd10, 8'h0B, 8'h00, 8'h00, 16'h4005, 3'b000, 19'h00000}, // R10 missing slot
        {4'd4,  8'h03, 8'h00, 8'h00, 16'hC006, 3'b001, 19'h00006}, // R4
        {4'd7,  8'h80, 8'h00, 8'h00, 16'h0009, 3'b001, 19'h0C009}, // R7 page 0
        {4'd7,  8'h80, 8'h00, 8'h00, 16'h400A, 3'b001, 19'h0800A}, // R7
        {4'd7,  8'h80, 8'h00, 8'h00, 16'h800B, 3'b001, 19'h0400B}, // R7
        {4'd7,  8'h87, 8'h00, 8'h00, 16'h0010, 3'b001, 19'h78010}, // R7 page 7
        {4'd7,  8'h87, 8'h00, 8'h00, 16'h4011, 3'b001, 19'h7C011}, // R7
        {4'd10, 8'h87, 8'h00, 8'h00, 16'h8012, 3'b000, 19'h00000}, // R10
        {4'd7,  8'h83, 8'h00, 8'h00, 16'h0013, 3'b001, 19'h48013}, // R7 page 3
        {4'd10, 8'h88, 8'h00, 8'h00, 16'h0014, 3'b000, 19'h00000}, // R10 page 8
        {4'd10, 8'h8E, 8'h00, 8'h00, 16'h0015, 3'b000, 19'h00000}, // R10 page 14 low
        {4'd9,  8'h8F, 8'h09, 8'h1F, 16'h0415, 3'b100, 19'h00015}, // R9 mirror
        {4'd8,  8'h8F, 8'h09, 8'h1F, 16'h4016, 3'b001, 19'h24016}, // R8 win1
        {4'd8,  8'h8F, 8'h09, 8'h1F, 16'h8017, 3'b010, 19'h7C017}, // R8 flash win2
        {4'd4,  8'h8F, 8'h09, 8'h1F, 16'hFFFF, 3'b001, 19'h03FFF}, // R4
        {4'd8,  8'h8E, 8'h09, 8'h1F, 16'h8018, 3'b001, 19'h7C018}, // R8 sram win2
        {4'd5,  8'h7F, 8'h02, 8'h04, 16'h2019, 3'b001, 19'h1E019}, // R5 ROM 7
        {4'd8,  8'h7F, 8'h02, 8'h04, 16'h801A, 3'b010, 19'h1001A}, // R8 ROM map
        {4'd8,  8'h7F, 8'h02, 8'h04, 16'h401B, 3'b001, 19'h0801B}, // R8
        {4'd10, 8'h0C, 8'h00, 8'h00, 16'h4000, 3'b000, 19'h00000}  // R10 page 12
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] port, input logic [7:0] data);
        @(negedge clk);
        io_addr = port; io_wdata = data; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read_check(input logic [7:0] port, input logic [7:0] exp,
                                 input string req);
        @(negedge clk);
        io_addr = port;
        #1;
        check(io_rdata == exp, req, "io_rdata", 32'(io_rdata), 32'(exp));
    endtask

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: state after reset
        io_read_check(8'h00, 8'h8F, "R1");
        io_read_check(8'hD0, 8'h00, "R1");
        io_read_check(8'hD1, 8'h00, "R1");
        cpu_addr = 16'h0000; #1;
        check(rom_cs && !sram_cs && !flash_cs, "R1", "rom_cs",
              32'({rom_cs, flash_cs, sram_cs}), 32'b100);
        check(flash_visible == 1'b1, "R1", "flash_visible", 32'(flash_visible), 1);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [7:0]  c, w1, w2;
            logic [15:0] a;
            logic [2:0]  cs;
            logic [18:0] ph;
            logic [7:0]  rd;
            string       rs;
            {rq, c, w1, w2, a, cs, ph} = VEC[i];
            rs = $sformatf("R%0d", rq);
            io_write(8'h00, c);
            io_write(8'hD0, w1);
            io_write(8'hD1, w2);
            @(negedge clk);
            cpu_addr = a;
            #1;
            check({rom_cs, flash_cs, sram_cs} == cs, rs, $sformatf("selects @%h", a),
                  32'({rom_cs, flash_cs, sram_cs}), 32'(cs));
            if (cs != 3'b000)
                check(phys_addr == ph, rs, $sformatf("phys_addr @%h", a),
                      32'(phys_addr), 32'(ph));
            rd = cs[0] ? 8'hA5 : cs[1] ? 8'h5A : cs[2] ? 8'h3C : 8'hFF;
            check(cpu_rdata == rd, (cs == 3'b000) ? "R10" : "R11", "cpu_rdata",
                  32'(cpu_rdata), 32'(rd));
            check(flash_visible == (c[3:0] == 4'hF), "R12", "flash_visible",
                  32'(flash_visible), 32'(c[3:0] == 4'hF));
        end

        // R2: control byte readback
        io_write(8'h00, 8'hA5);
        io_read_check(8'h00, 8'hA5, "R2");
        // R3: window width and unknown port
        io_write(8'hD0, 8'hFF);
        io_read_check(8'hD0, 8'h1F, "R3");
        io_write(8'hD1, 8'hE3);
        io_read_check(8'hD1, 8'h03, "R3");
        io_read_check(8'h42, 8'hFF, "R3");
        // R3: write to another port leaves the windows alone
        io_write(8'h42, 8'h07);
        io_read_check(8'hD0, 8'h1F, "R3");
        // R2: data without strobe is ignored
        @(negedge clk);
        io_addr = 8'h00; io_wdata = 8'h11; io_wr = 1'b0;
        io_read_check(8'h00, 8'hA5, "R2");

        // R1: reset in mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        io_read_check(8'h00, 8'h8F, "R1");
        io_read_check(8'hD0, 8'h00, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule